// File: doc/BRIEF.md
# On-Die Termination and Output-Enable Controller

This block sits on the device side of a DDR3-class memory and decides, every clock, which on-die termination setting drives the data pins: none, the nominal setting, or the separate write setting. It also decides whether the output drivers are connected. It takes the stored mode-register words, the termination request pin, a write-in-progress flag and a delay-locked-loop-bypass flag. It returns a select code, the termination value that goes with it, and a driver enable.

The mode-register words come in whole. The block picks out the termination fields itself and treats reserved encodings as "no termination". A write can bring in the write setting even when nominal termination is switched off. When the delay-locked loop is bypassed, all termination is suppressed. The outputs are registered, so every change shows up one clock after the inputs that cause it.

Top module: `odt_term_ctrl`

## Requirements
- R1: The nominal code is {mr1[9], mr1[6], mr1[2]} (bit 9 most significant). Codes 1 to 5 are usable. Code 0 means nominal termination is disabled, and codes 6 and 7 are reserved; both are treated as no nominal termination.
- R2: The write code is {mr2[10], mr2[9]}. Codes 1 and 2 are usable. Code 0 means write termination is disabled and code 3 is reserved; neither selects the write setting.
- R3: When the termination pin was low at the sampling edge, the select output is off (2'b00) and the value output is 0, whatever the mode registers hold.
- R4: When the DLL-bypass flag was high at the sampling edge, the select output is off and the value is 0, even with the pin high and a write in progress.
- R5: With the pin high, the bypass flag low, a write in progress and a usable write code, the select output is write (2'b10) and the value output is the write code, zero-extended to 3 bits.
- R6: The write setting of R5 is applied even when the nominal code is 0 or reserved.
- R7: With the pin high and the bypass flag low, in any case that R5 does not cover, a usable nominal code gives select nominal (2'b01) with the value output equal to that code. Otherwise the select is off.
- R8: The driver enable output is the inverse of mr1[12]: mr1[12] = 1 disconnects the outputs (0) and mr1[12] = 0 keeps them connected (1). The termination decision does not depend on mr1[12].
- R9: All outputs are registered and follow the inputs one clock edge later. Reset (active low, asynchronous) gives select off, value 0 and driver enable 1.
- R10: The select output never has both bits set. Whenever it is off, the value output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mr1_i | input | MR_W (16) | Stored mode register 1 word |
| mr2_i | input | MR_W (16) | Stored mode register 2 word |
| odt_i | input | 1 | Termination request pin |
| wr_busy_i | input | 1 | A write burst is in progress |
| dll_off_i | input | 1 | The delay-locked loop is bypassed |
| term_sel_o | output | 2 | 00 off, 01 nominal, 10 write |
| term_val_o | output | 3 | Termination code in use, 0 when off |
| drv_en_o | output | 1 | Output drivers connected |

## Verification
The assertions assume that every input is driven to a known 0 or 1 on each rising edge. They also assume the inputs are held steady across the edge, so that the value sampled one cycle is the one the registered outputs answer for on the next. The bench changes inputs only on falling edges and drives defined values from time zero. The random mode-register words cover all reserved field codes and the qoff bit, and the pin, write and bypass flags are weighted so that each priority branch is reached often.

// File: rtl/odt_term_pkg.sv
package odt_term_pkg;

  // Termination select encoding: at most one bit set.
  typedef enum logic [1:0] {
    TERM_OFF = 2'b00,
    TERM_NOM = 2'b01,
    TERM_WR  = 2'b10
  } term_sel_e;

  localparam int NOM_W   = 3;
  localparam int WR_W    = 2;
  localparam int VAL_W   = NOM_W;

  // Field positions the device decodes inside the mode-register words.
  localparam int NOM_B0  = 2;
  localparam int NOM_B1  = 6;
  localparam int NOM_B2  = 9;
  localparam int QOFF_B  = 12;
  localparam int WR_LSB  = 9;

  // Highest usable code of each field; codes above are reserved.
  localparam int NOM_MAX = 5;
  localparam int WR_MAX  = 2;

  function automatic logic nom_usable(input logic [NOM_W-1:0] c);
    return (c != '0) && (int'(c) <= NOM_MAX);
  endfunction

  function automatic logic wr_usable(input logic [WR_W-1:0] c);
    return (c != '0) && (int'(c) <= WR_MAX);
  endfunction

endpackage

// File: rtl/odt_field_decode.sv
module odt_field_decode
  import odt_term_pkg::*;
#(
  parameter int MR_W = 16
) (
  input  logic [MR_W-1:0]  mr1,
  input  logic [MR_W-1:0]  mr2,
  output logic [NOM_W-1:0] nom_code,
  output logic             nom_ok,
  output logic [WR_W-1:0]  wr_code,
  output logic             wr_ok,
  output logic             qoff
);

  // Fold the whole words so every bit counts as read.
  logic unused_mr_bits;
  assign unused_mr_bits = ^{mr1, mr2};

  assign nom_code = {mr1[NOM_B2], mr1[NOM_B1], mr1[NOM_B0]};
  assign wr_code  = mr2[WR_LSB +: WR_W];
  assign nom_ok   = nom_usable(nom_code);
  assign wr_ok    = wr_usable(wr_code);
  assign qoff     = mr1[QOFF_B];

endmodule

// File: rtl/odt_term_select.sv
module odt_term_select
  import odt_term_pkg::*;
(
  input  logic             odt,
  input  logic             wr_busy,
  input  logic             dll_off,
  input  logic [NOM_W-1:0] nom_code,
  input  logic             nom_ok,
  input  logic [WR_W-1:0]  wr_code,
  input  logic             wr_ok,
  output logic             gate_open,
  output logic             wr_pick,
  output term_sel_e        sel_nxt,
  output logic [VAL_W-1:0] val_nxt
);

  // Termination is allowed only with the pin high and the loop locked.
  assign gate_open = odt && !dll_off;
  assign wr_pick   = gate_open && wr_busy && wr_ok;

  always_comb begin
    sel_nxt = TERM_OFF;
    val_nxt = '0;
    if (wr_pick) begin
      sel_nxt = TERM_WR;
      val_nxt = VAL_W'(wr_code);
    end else if (gate_open && nom_ok) begin
      sel_nxt = TERM_NOM;
      val_nxt = nom_code;
    end
  end

endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
  import odt_term_pkg::*;
#(
  parameter int MR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MR_W-1:0] mr1_i,
  input  logic [MR_W-1:0] mr2_i,
  input  logic            odt_i,
  input  logic            wr_busy_i,
  input  logic            dll_off_i,
  output logic [1:0]      term_sel_o,
  output logic [2:0]      term_val_o,
  output logic            drv_en_o
);

  logic [NOM_W-1:0] nom_code;
  logic             nom_ok;
  logic [WR_W-1:0]  wr_code;
  logic             wr_ok;
  logic             qoff;
  logic             gate_open;
  logic             wr_pick;
  term_sel_e        sel_nxt;
  logic [VAL_W-1:0] val_nxt;

  odt_field_decode #(.MR_W(MR_W)) u_dec (
    .mr1      (mr1_i),
    .mr2      (mr2_i),
    .nom_code (nom_code),
    .nom_ok   (nom_ok),
    .wr_code  (wr_code),
    .wr_ok    (wr_ok),
    .qoff     (qoff)
  );

  odt_term_select u_sel (
    .odt       (odt_i),
    .wr_busy   (wr_busy_i),
    .dll_off   (dll_off_i),
    .nom_code  (nom_code),
    .nom_ok    (nom_ok),
    .wr_code   (wr_code),
    .wr_ok     (wr_ok),
    .gate_open (gate_open),
    .wr_pick   (wr_pick),
    .sel_nxt   (sel_nxt),
    .val_nxt   (val_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_sel_o <= TERM_OFF;
      term_val_o <= '0;
      drv_en_o   <= 1'b1;
    end else begin
      term_sel_o <= sel_nxt;
      term_val_o <= val_nxt;
      drv_en_o   <= !qoff;
    end
  end

endmodule

// File: rtl/odt_term_ctrl_chk.sv
module odt_term_ctrl_chk
  import odt_term_pkg::*;
#(
  parameter int MR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MR_W-1:0]  mr1_i,
  input logic             odt_i,
  input logic             wr_busy_i,
  input logic             dll_off_i,
  input logic [NOM_W-1:0] nom_code,
  input logic             nom_ok,
  input logic [WR_W-1:0]  wr_code,
  input logic             wr_ok,
  input logic [1:0]       term_sel_o,
  input logic [2:0]       term_val_o,
  input logic             drv_en_o
);

  // R3
  a_r3_pin_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !odt_i |=> (term_sel_o == 2'b00));

  // R4
  a_r4_dll_off_off: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off_i |=> (term_sel_o == 2'b00));

  // R5, R6
  a_r5_write_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_i && !dll_off_i && wr_busy_i && wr_ok)
    |=> (term_sel_o == 2'b10) && (term_val_o == {1'b0, $past(wr_code)}));

  // R7
  a_r7_nominal_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_i && !dll_off_i && nom_ok && !(wr_busy_i && wr_ok))
    |=> (term_sel_o == 2'b01) && (term_val_o == $past(nom_code)));

  // R8
  a_r8_qoff_drv: assert property (@(posedge clk) disable iff (!rst_n)
    mr1_i[QOFF_B] |=> !drv_en_o);

  a_r8_drv_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !mr1_i[QOFF_B] |=> drv_en_o);

  // R10
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(term_sel_o));

  a_r10_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (term_sel_o == 2'b00) |-> (term_val_o == 3'd0));

endmodule

bind odt_term_ctrl odt_term_ctrl_chk #(.MR_W(MR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mr1_i      (mr1_i),
  .odt_i      (odt_i),
  .wr_busy_i  (wr_busy_i),
  .dll_off_i  (dll_off_i),
  .nom_code   (nom_code),
  .nom_ok     (nom_ok),
  .wr_code    (wr_code),
  .wr_ok      (wr_ok),
  .term_sel_o (term_sel_o),
  .term_val_o (term_val_o),
  .drv_en_o   (drv_en_o)
);

// File: tb/odt_term_ctrl_tb.sv
module odt_term_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mr1_i = '0;
  logic [15:0] mr2_i = '0;
  logic        odt_i = 1'b0;
  logic        wr_busy_i = 1'b0;
  logic        dll_off_i = 1'b0;
  logic [1:0]  term_sel_o;
  logic [2:0]  term_val_o;
  logic        drv_en_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  odt_term_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mr1_i      (mr1_i),
    .mr2_i      (mr2_i),
    .odt_i      (odt_i),
    .wr_busy_i  (wr_busy_i),
    .dll_off_i  (dll_off_i),
    .term_sel_o (term_sel_o),
    .term_val_o (term_val_o),
    .drv_en_o   (drv_en_o)
  );

  // Place a 3-bit nominal code, the qoff bit and filler into a register 1 word.
  function automatic logic [15:0] mk_mr1(logic [2:0] c, logic q, logic [15:0] fill);
    logic [15:0] w = fill;
    w[2]  = c[0];
    w[6]  = c[1];
    w[9]  = c[2];
    w[12] = q;
    return w;
  endfunction

  function automatic logic [15:0] mk_mr2(logic [1:0] c, logic [15:0] fill);
    logic [15:0] w = fill;
    w[10:9] = c;
    return w;
  endfunction

  // Reference model: {sel[1:0], val[2:0], drv}.
  function automatic logic [5:0] model(logic [15:0] m1, logic [15:0] m2,
                                       logic pin, logic wb, logic dl);
    logic [2:0] n = {m1[9], m1[6], m1[2]};
    logic [1:0] w = {m2[10], m2[9]};
    logic nuse, wuse;
    logic [1:0] s = 2'b00;
    logic [2:0] v = 3'd0;
    case (n) 3'd1, 3'd2, 3'd3, 3'd4, 3'd5: nuse = 1'b1; default: nuse = 1'b0; endcase
    case (w) 2'd1, 2'd2: wuse = 1'b1; default: wuse = 1'b0; endcase
    if (pin === 1'b1 && dl === 1'b0) begin
      if (wb && wuse) begin s = 2'b10; v = {1'b0, w}; end
      else if (nuse)  begin s = 2'b01; v = n; end
    end
    return {s, v, ~m1[12]};
  endfunction

  task automatic check(string tag, logic [5:0] e);
    n_checks++;
    if ({term_sel_o, term_val_o, drv_en_o} !== e) begin
      n_errs++;
      $display("FAIL %s: sel=%b val=%0d drv=%b expected sel=%b val=%0d drv=%b",
               tag, term_sel_o, term_val_o, drv_en_o, e[5:4], e[3:1], e[0]);
    end
  endtask

  // Drive on a falling edge, check on the next falling edge (one rising edge between).
  task automatic step(string tag, logic [15:0] m1, logic [15:0] m2,
                      logic pin, logic wb, logic dl);
    @(negedge clk);
    mr1_i = m1; mr2_i = m2; odt_i = pin; wr_busy_i = wb; dll_off_i = dl;
    @(negedge clk);
    check(tag, model(m1, m2, pin, wb, dl));
  endtask

  initial begin
    #(20 * 200000);
    n_errs++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [5:0] prev;
    void'($urandom(32'h0D7E_5EED));
    // R9: reset state, with the pin high and the qoff bit set while held in reset.
    mr1_i = mk_mr1(3'd2, 1'b1, 16'h0); odt_i = 1'b1;
    #35;
    check("R9 reset", {2'b00, 3'd0, 1'b1});
    @(negedge clk);
    mr1_i = '0; odt_i = 1'b0;
    rst_n = 1'b1;

    // R3: pin low blocks every setting.
    step("R3 pin low", mk_mr1(3'd1, 1'b0, 16'h0), mk_mr2(2'd1, 16'h0), 1'b0, 1'b1, 1'b0);
    // R4: loop bypassed blocks termination but not the drivers.
    step("R4 dll off", mk_mr1(3'd3, 1'b0, 16'h0), mk_mr2(2'd2, 16'h0), 1'b1, 1'b1, 1'b1);
    step("R4 dll off nowr", mk_mr1(3'd3, 1'b0, 16'h0), 16'h0, 1'b1, 1'b0, 1'b1);
    // R1: every nominal code with no write in progress.
    for (int c = 0; c < 8; c++)
      step("R1 nominal code", mk_mr1(3'(c), 1'b0, 16'hA5A5 & 16'hED9B), 16'h0, 1'b1, 1'b0, 1'b0);
    // R2: every write code while writing, nominal set to 2.
    for (int c = 0; c < 4; c++)
      step("R2 write code", mk_mr1(3'd2, 1'b0, 16'h0), mk_mr2(2'(c), 16'hFFFF), 1'b1, 1'b1, 1'b0);
    // R5: write setting wins over a usable nominal one.
    step("R5 write over nominal", mk_mr1(3'd4, 1'b0, 16'h0), mk_mr2(2'd1, 16'h0), 1'b1, 1'b1, 1'b0);
    // R6: write setting with nominal disabled and with nominal reserved.
    step("R6 write nominal off", mk_mr1(3'd0, 1'b0, 16'h0), mk_mr2(2'd2, 16'h0), 1'b1, 1'b1, 1'b0);
    step("R6 write nominal rsvd", mk_mr1(3'd7, 1'b0, 16'h0), mk_mr2(2'd1, 16'h0), 1'b1, 1'b1, 1'b0);
    // R7: falls back to nominal when the write code is disabled or reserved.
    step("R7 nominal during write", mk_mr1(3'd5, 1'b0, 16'h0), mk_mr2(2'd0, 16'h0), 1'b1, 1'b1, 1'b0);
    step("R7 nominal wr rsvd", mk_mr1(3'd3, 1'b0, 16'h0), mk_mr2(2'd3, 16'h0), 1'b1, 1'b1, 1'b0);
    // R8: qoff disconnects the drivers, termination unaffected.
    step("R8 qoff set", mk_mr1(3'd1, 1'b1, 16'h0), 16'h0, 1'b1, 1'b0, 1'b0);
    step("R8 qoff clear", mk_mr1(3'd1, 1'b0, 16'h0), 16'h0, 1'b1, 1'b0, 1'b0);

    // R9: outputs hold until the next rising edge.
    @(negedge clk);
    prev = {term_sel_o, term_val_o, drv_en_o};
    mr1_i = mk_mr1(3'd0, 1'b1, 16'h0); mr2_i = mk_mr2(2'd2, 16'h0);
    odt_i = 1'b1; wr_busy_i = 1'b1; dll_off_i = 1'b0;
    #5;
    check("R9 held before edge", prev);
    @(negedge clk);
    check("R9 after one edge", {2'b10, 3'd2, 1'b0});

    // Random mix covering all priority branches (R1 R2 R3 R4 R5 R7 R8 R10).
    for (int i = 0; i < 400; i++) begin
      logic [15:0] m1 = 16'($urandom);
      logic [15:0] m2 = 16'($urandom);
      logic pin = ($urandom % 4) != 0;
      logic wb  = $urandom % 2;
      logic dl  = ($urandom % 6) == 0;
      logic [5:0] e = model(m1, m2, pin, wb, dl);
      string tag;
      if (dl && pin)          tag = "R4 random";
      else if (!pin)          tag = "R3 random";
      else if (e[5:4] == 2'b10) tag = "R5 random";
      else if (e[5:4] == 2'b01) tag = "R7 random";
      else                    tag = "R1 R2 random off";
      step(tag, m1, m2, pin, wb, dl);
    end

    // R9: asynchronous reset returns the reset state mid-run.
    @(negedge clk);
    mr1_i = mk_mr1(3'd2, 1'b1, 16'h0); odt_i = 1'b1; wr_busy_i = 1'b0; dll_off_i = 1'b0;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2 check("R9 async reset", {2'b00, 3'd0, 1'b1});
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule